// File: doc/BRIEF.md
# Line-Synchronous Pixel Capture Front End

This block sits between a video digitizer and the frame storage path. It takes the digitizer's 24-bit RGB bus, its data clock, and its horizontal and vertical sync. It registers every input on the rising edge of the data clock. The horizontal sync edge re-anchors a sample counter at the start of each line. The block throws away the pipeline-flush samples that the digitizer puts at the head of every line, then a programmable number of back-porch samples. After that it forwards exactly one horizontal resolution's worth of pixels as a single burst. The burst is marked with a start-of-line flag, and the first burst of each frame also carries a start-of-frame flag.

The output has no backpressure: one beat leaves per clock while a burst is open. A line cut short by an early horizontal sync is still delivered at full length. Its missing tail is filled with zero pixels and a short-line error pulse is raised. The line that began with that early sync is not captured, and capture resumes at the sync after it. Capture is held off until the configuration logic raises its ready signal and a vertical sync rising edge is then seen, so a partial frame never reaches the output. Both syncs are active high.

Top module: `line_capture_front`

## Requirements
- R1: A forwarded pixel leaves on `out_data` unchanged and in line order, with red in bits 23:16, green in bits 15:8 and blue in bits 7:0.
- R2: Sample 0 of a line is the pixel sampled at the same rising clock edge at which `hsync_in` is first seen high. Samples 0 to FLUSH-1 (FLUSH = 4) are never forwarded.
- R3: After the flush samples, a further `skip_cnt` samples are dropped. `skip_cnt` is taken at the start of each line, so the first forwarded pixel is sample FLUSH + `skip_cnt`.
- R4: A line whose next `hsync_in` rise comes at sample FLUSH + `skip_cnt` + H_RES or later produces exactly H_RES beats. The first beat has `out_sol` set and no other beat has it.
- R5: A `hsync_in` rise during the drop phase (before sample FLUSH + `skip_cnt`) restarts the line count from zero. It produces no beats and no short-line error.
- R6: A `hsync_in` rise at sample L, where FLUSH + `skip_cnt` <= L < FLUSH + `skip_cnt` + H_RES, raises a one-cycle `short_line` pulse. The line's L - FLUSH - `skip_cnt` real pixels are followed by zero pixels up to H_RES beats. The line that this sync starts is not captured.
- R7: No beat is produced while `cfg_ready` is low. After `cfg_ready` rises, no beat is produced until a `vsync_in` rising edge has been seen.
- R8: The first beat after every `vsync_in` rising edge carries `out_sof` together with `out_sol`. No other beat carries `out_sof`.
- R9: Dropping `cfg_ready` stops all beats from the next clock on. Capture after `cfg_ready` returns needs a fresh `vsync_in` rising edge.
- R10: During and right after reset, `out_valid`, `out_sol`, `out_sof`, `short_line` and `out_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Digitizer output data clock; every input is sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_ready | input | 1 | High once the digitizer has been configured; gates all capture |
| skip_cnt | input | SKIP_W | Back-porch samples dropped after the flush samples, taken at each line start |
| hsync_in | input | 1 | Horizontal sync, active high |
| vsync_in | input | 1 | Vertical sync, active high |
| pix_in | input | 3*CH_W | RGB pixel from the digitizer |
| out_valid | output | 1 | One pixel beat present this cycle |
| out_data | output | 3*CH_W | Pixel of the beat (zero on padding beats) |
| out_sol | output | 1 | Beat is the first of a line burst |
| out_sof | output | 1 | Beat is the first of a frame |
| short_line | output | 1 | One-cycle pulse: the current line was cut short and is being padded |

## Verification
A wrong internal state shows up directly at the ports. If the sample counter is off after the sync edge, the first forwarded pixel carries the wrong sample index. This is visible on the first beat of the affected line, two clocks after that sample enters. If the burst counter is wrong, the burst has the wrong number of beats, or `out_sol` appears mid-burst, within one line time. If the frame-arm or short-line tracking is stuck, beats appear before a frame edge, `out_sof` is missing, or the line after a padded line leaks out. Each of these is visible within the next line.

// File: rtl/line_capture_pkg.sv
// Package: shared types for the line capture front end.
// Assumes: nothing beyond a standard SystemVerilog compile order (first file).
package line_capture_pkg;

    // Sequencer states, in the order a line passes through them.
    typedef enum logic [2:0] {
        ST_ARM    = 3'd0,  // waiting for ready and a frame edge
        ST_WAIT_H = 3'd1,  // armed, waiting for a line edge
        ST_DROP   = 3'd2,  // discarding flush and back-porch samples
        ST_ACTIVE = 3'd3,  // forwarding the burst
        ST_HOLD   = 3'd4,  // burst complete, waiting for next line edge
        ST_PAD    = 3'd5   // emitting zero pixels to finish a short line
    } cap_state_t;

endpackage

// File: rtl/sync_sampler.sv
// Module: sync_sampler
// Registers the pixel bus and both syncs on the rising data-clock edge.
// Produces single-cycle rising-edge strobes for the syncs.
// Assumes: both syncs are active high and synchronous to clk.
module sync_sampler #(
    parameter int PIX_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] pix_in,
    input  logic             hsync_in,
    input  logic             vsync_in,
    output logic [PIX_W-1:0] pix_q,
    output logic             hs_rise,
    output logic             vs_rise
);

    logic hs_q, hs_d;
    logic vs_q, vs_d;

    // Input capture register plus one delay stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_q <= '0;
            hs_q  <= 1'b0;
            hs_d  <= 1'b0;
            vs_q  <= 1'b0;
            vs_d  <= 1'b0;
        end else begin
            pix_q <= pix_in;
            hs_q  <= hsync_in;
            hs_d  <= hs_q;
            vs_q  <= vsync_in;
            vs_d  <= vs_q;
        end
    end

    // Edge strobes line up with the sample captured alongside the first high sync.
    always_comb begin
        hs_rise = hs_q & ~hs_d;
        vs_rise = vs_q & ~vs_d;
    end

endmodule

// File: rtl/line_sequencer.sv
// Module: line_sequencer
// Tracks the position inside each line and decides which samples become beats.
// Drops FLUSH + skip samples, forwards H_RES, pads short lines and arms on frames.
// Assumes: hs_rise/vs_rise are aligned with the sample currently in the capture register.
module line_sequencer
    import line_capture_pkg::*;
#(
    parameter int H_RES  = 640,
    parameter int FLUSH  = 4,
    parameter int SKIP_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_ready,
    input  logic              hs_rise,
    input  logic              vs_rise,
    input  logic [SKIP_W-1:0] skip_cnt,
    output logic              emit,
    output logic              emit_zero,
    output logic              emit_first,
    output logic              emit_sof,
    output logic              short_pulse
);

    localparam int MAX_POS = FLUSH + (1 << SKIP_W) + H_RES;
    localparam int CNT_W   = $clog2(MAX_POS + 1);
    localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(H_RES - 1);

    cap_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] drop_last;
    logic [CNT_W-1:0] drop_total;
    logic             sof_pend;

    // Number of samples to discard for a line starting now.
    always_comb begin
        drop_total = CNT_W'(FLUSH) + CNT_W'(skip_cnt);
    end

    // Line position state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_ARM;
            cnt       <= '0;
            drop_last <= '0;
        end else if (!cfg_ready) begin
            state <= ST_ARM;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_ARM: begin
                    if (vs_rise) state <= ST_WAIT_H;
                end
                ST_WAIT_H, ST_HOLD, ST_DROP: begin
                    if (hs_rise) begin
                        drop_last <= drop_total - 1'b1;
                        if (drop_total == CNT_W'(1)) begin
                            state <= ST_ACTIVE;
                            cnt   <= '0;
                        end else begin
                            state <= ST_DROP;
                            cnt   <= CNT_W'(1);
                        end
                    end else if (state == ST_DROP) begin
                        if (cnt == drop_last) begin
                            state <= ST_ACTIVE;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_ACTIVE: begin
                    if (cnt == LAST_BEAT) begin
                        state <= hs_rise ? ST_WAIT_H : ST_HOLD;
                        cnt   <= '0;
                    end else begin
                        state <= hs_rise ? ST_PAD : ST_ACTIVE;
                        cnt   <= cnt + 1'b1;
                    end
                end
                ST_PAD: begin
                    if (cnt == LAST_BEAT) begin
                        state <= ST_WAIT_H;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    state <= ST_ARM;
                    cnt   <= '0;
                end
            endcase
        end
    end

    // Start-of-frame marker waits for the first beat after each frame edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !cfg_ready) begin
            sof_pend <= 1'b0;
        end else begin
            if (emit && emit_first) sof_pend <= 1'b0;
            if (vs_rise)            sof_pend <= 1'b1;
        end
    end

    // Beat decode for the output stage.
    always_comb begin
        emit        = cfg_ready && (state == ST_ACTIVE || state == ST_PAD);
        emit_zero   = (state == ST_PAD) || hs_rise;
        emit_first  = (cnt == '0);
        emit_sof    = sof_pend && (cnt == '0);
        short_pulse = cfg_ready && (state == ST_ACTIVE) && hs_rise;
    end

    // A padded line always finishes at the burst end, never reopens a burst.
    assert_pad_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_PAD |=> (state == ST_PAD || state == ST_WAIT_H || state == ST_ARM));

    // A line edge in the drop phase only restarts the count.
    assert_realign_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ready && state == ST_DROP && hs_rise) |=> (state == ST_DROP || state == ST_ACTIVE));

endmodule

// File: rtl/pixel_out_stage.sv
// Module: pixel_out_stage
// Registers the beat, its markers and the short-line pulse onto the output ports.
// Padding beats carry zero data.
// Assumes: the decode inputs are valid in the same cycle as pix_q.
module pixel_out_stage #(
    parameter int PIX_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] pix_q,
    input  logic             emit,
    input  logic             emit_zero,
    input  logic             emit_first,
    input  logic             emit_sof,
    input  logic             short_pulse,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_data,
    output logic             out_sol,
    output logic             out_sof,
    output logic             short_line
);

    // Output register: one beat per clock, no backpressure.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_data   <= '0;
            out_sol    <= 1'b0;
            out_sof    <= 1'b0;
            short_line <= 1'b0;
        end else begin
            out_valid  <= emit;
            out_data   <= (emit && !emit_zero) ? pix_q : '0;
            out_sol    <= emit && emit_first;
            out_sof    <= emit && emit_sof;
            short_line <= short_pulse;
        end
    end

    // Frame marker only ever rides on a line-start beat.
    assert_sof_on_sol_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> (out_sol && out_valid));

endmodule

// File: rtl/line_capture_front.sv
// Module: line_capture_front (top)
// Captures digitizer pixels into fixed-length per-line bursts with line/frame markers.
// Assumes: clk is the digitizer data clock; syncs are active high; cfg_ready is synchronous.
module line_capture_front #(
    parameter int CH_W   = 8,
    parameter int H_RES  = 640,
    parameter int FLUSH  = 4,
    parameter int SKIP_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_ready,
    input  logic [SKIP_W-1:0]   skip_cnt,
    input  logic                hsync_in,
    input  logic                vsync_in,
    input  logic [3*CH_W-1:0]   pix_in,
    output logic                out_valid,
    output logic [3*CH_W-1:0]   out_data,
    output logic                out_sol,
    output logic                out_sof,
    output logic                short_line
);

    localparam int PIX_W = 3 * CH_W;
    localparam int BEAT_W = $clog2(H_RES + 1);

    logic [PIX_W-1:0] pix_q;
    logic             hs_rise, vs_rise;
    logic             emit, emit_zero, emit_first, emit_sof, short_pulse;

    sync_sampler #(.PIX_W(PIX_W)) u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .pix_in   (pix_in),
        .hsync_in (hsync_in),
        .vsync_in (vsync_in),
        .pix_q    (pix_q),
        .hs_rise  (hs_rise),
        .vs_rise  (vs_rise)
    );

    line_sequencer #(.H_RES(H_RES), .FLUSH(FLUSH), .SKIP_W(SKIP_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_ready   (cfg_ready),
        .hs_rise     (hs_rise),
        .vs_rise     (vs_rise),
        .skip_cnt    (skip_cnt),
        .emit        (emit),
        .emit_zero   (emit_zero),
        .emit_first  (emit_first),
        .emit_sof    (emit_sof),
        .short_pulse (short_pulse)
    );

    pixel_out_stage #(.PIX_W(PIX_W)) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .pix_q       (pix_q),
        .emit        (emit),
        .emit_zero   (emit_zero),
        .emit_first  (emit_first),
        .emit_sof    (emit_sof),
        .short_pulse (short_pulse),
        .out_valid   (out_valid),
        .out_data    (out_data),
        .out_sol     (out_sol),
        .out_sof     (out_sof),
        .short_line  (short_line)
    );

    // Checker state: beats seen since the last line start, counted at the ports.
    logic [BEAT_W-1:0] line_beats;

    // Beat counter for the burst-length assertions.
    always_ff @(posedge clk) begin
        if (!rst_n || !cfg_ready) begin
            line_beats <= '0;
        end else if (out_valid) begin
            line_beats <= out_sol ? BEAT_W'(1) : line_beats + 1'b1;
        end
    end

    // A new burst opens only after the previous one reached full length.
    assert_burst_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ready && out_valid && out_sol) |-> (line_beats == '0 || line_beats == BEAT_W'(H_RES)));

    // Continuation beats stay inside an open, unfinished burst.
    assert_no_overrun_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ready && out_valid && !out_sol) |-> (line_beats != '0 && line_beats < BEAT_W'(H_RES)));

    // Without ready the port goes quiet on the next clock.
    assert_ready_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ready |=> !out_valid);

endmodule

// File: tb/tb_line_capture_front.sv
module tb_line_capture_front;

    localparam int CW = 8;
    localparam int HR = 8;
    localparam int FL = 4;
    localparam int SW = 4;
    localparam int NCASE = 10;

    // Line vectors: {skip, line length in samples, vsync pulse before the line}
    localparam int CASES [0:NCASE-1][0:2] = '{
        '{0, 14, 1},   // full line, first of frame
        '{2, 16, 0},   // full line with back-porch skip
        '{3,  9, 0},   // short: 2 real pixels then padding
        '{0, 20, 0},   // lost line after short
        '{0,  2, 0},   // sync inside drop phase: realign
        '{1,  5, 0},   // short at first slot: all padding
        '{0, 20, 0},   // lost line after short
        '{5, 17, 0},   // exact minimum full length
        '{0, 12, 1},   // new frame, exact length
        '{15, 30, 0}   // largest skip
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_ready = 1'b0;
    logic [SW-1:0]     skip_cnt = '0;
    logic              hsync_in = 1'b0;
    logic              vsync_in = 1'b0;
    logic [3*CW-1:0]   pix_in = '0;
    logic              out_valid;
    logic [3*CW-1:0]   out_data;
    logic              out_sol, out_sof, short_line;

    line_capture_front #(.CH_W(CW), .H_RES(HR), .FLUSH(FL), .SKIP_W(SW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_ready(cfg_ready), .skip_cnt(skip_cnt),
        .hsync_in(hsync_in), .vsync_in(vsync_in), .pix_in(pix_in),
        .out_valid(out_valid), .out_data(out_data), .out_sol(out_sol),
        .out_sof(out_sof), .short_line(short_line)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    logic [23:0] got_d [0:1023];
    bit          got_sol [0:1023];
    bit          got_sof [0:1023];
    int          got_n = 0;
    int          short_seen = 0;

    logic [23:0] exp_d [0:1023];
    bit          exp_sol [0:1023];
    bit          exp_sof [0:1023];
    int          exp_n = 0;
    int          exp_short = 0;

    bit armed = 0;
    bit sof_pend = 0;
    bit lost_next = 0;

    // Output monitor, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid && got_n < 1024) begin
                got_d[got_n]   = out_data;
                got_sol[got_n] = out_sol;
                got_sof[got_n] = out_sof;
                got_n++;
            end
            if (short_line) short_seen++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            hsync_in = 1'b0;
            pix_in   = '0;
            @(negedge clk);
        end
    endtask

    task automatic push(input logic [23:0] d, input bit s, input bit f);
        exp_d[exp_n]   = d;
        exp_sol[exp_n] = s;
        exp_sof[exp_n] = f;
        exp_n++;
    endtask

    // Drives one line and records the beats the requirements call for.
    task automatic drive_line(input int id, input int skip, input int len);
        int v;
        int nreal;
        if (armed) begin
            if (lost_next) begin
                lost_next = 0;                       // R6: line after a short one
            end else if (len >= FL + skip) begin
                v = len - FL - skip;
                nreal = (v >= HR) ? HR : v;
                for (int k = 0; k < HR; k++) begin
                    if (k < nreal) push({8'(id), 8'(FL + skip + k), 8'h5A}, k == 0, k == 0 && sof_pend);
                    else           push(24'h0, k == 0, k == 0 && sof_pend);
                    if (k == 0) sof_pend = 0;
                end
                if (v < HR) begin
                    exp_short++;
                    lost_next = 1;
                end
            end
        end
        skip_cnt = SW'(skip);
        for (int i = 0; i < len; i++) begin
            hsync_in = (i == 0);
            pix_in   = {8'(id), 8'(i), 8'h5A};
            @(negedge clk);
        end
    endtask

    task automatic pulse_vsync();
        hsync_in = 1'b0;
        pix_in   = '0;
        vsync_in = 1'b1;
        @(negedge clk);
        vsync_in = 1'b0;
        @(negedge clk);
        if (cfg_ready) begin
            armed    = 1;
            sof_pend = 1;
        end
    endtask

    task automatic compare(input int base);
        check(got_n == exp_n, "R4", "beat count", got_n, exp_n);
        for (int i = base; i < exp_n && i < got_n; i++) begin
            check(got_d[i] == exp_d[i], (exp_d[i] == 0) ? "R6" : "R1", "pixel", got_d[i], exp_d[i]);
            check(got_sol[i] == exp_sol[i], "R4", "sol flag", got_sol[i], exp_sol[i]);
            check(got_sof[i] == exp_sof[i], "R8", "sof flag", got_sof[i], exp_sof[i]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int base;
        int held;
        repeat (3) @(negedge clk);
        // R10: reset state
        check(out_valid == 0, "R10", "valid in reset", out_valid, 0);
        check(out_sol == 0 && out_sof == 0, "R10", "markers in reset", {out_sol, out_sof}, 0);
        check(short_line == 0, "R10", "short in reset", short_line, 0);
        check(out_data == 0, "R10", "data in reset", out_data, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 0, "R10", "valid after reset", out_valid, 0);

        // R7: frame edge and line without ready produce nothing
        pulse_vsync();
        drive_line(1, 0, 14);
        idle(4);
        check(got_n == 0, "R7", "beats before ready", got_n, 0);

        // R7: ready but no frame edge yet
        cfg_ready = 1'b1;
        drive_line(2, 0, 14);
        idle(4);
        check(got_n == 0, "R7", "beats before first frame edge", got_n, 0);

        // Vector table: R1 R2 R3 R4 R5 R6 R8
        for (int c = 0; c < NCASE; c++) begin
            if (CASES[c][2] != 0) pulse_vsync();
            drive_line(16 + c, CASES[c][0], CASES[c][1]);
        end
        idle(20);
        compare(0);
        check(short_seen == exp_short, "R6", "short-line pulses", short_seen, exp_short);

        // R9: ready dropped mid-burst
        skip_cnt = '0;
        for (int i = 0; i < 14; i++) begin
            hsync_in = (i == 0);
            pix_in   = {8'hEE, 8'(i), 8'h5A};
            if (i == 7) cfg_ready = 1'b0;
            @(negedge clk);
            if (i == 7) check(out_valid == 0, "R9", "valid one clock after ready low", out_valid, 0);
        end
        held = got_n;
        armed = 0;
        lost_next = 0;
        idle(4);
        check(got_n == held, "R9", "no beats while not ready", got_n, held);

        // R9: ready back, no frame edge: still nothing
        cfg_ready = 1'b1;
        drive_line(48, 0, 14);
        idle(4);
        check(got_n == held, "R9", "no beats without new frame edge", got_n, held);

        // R9 / R8: new frame edge resumes capture with frame marker
        exp_n = got_n;
        base  = got_n;
        pulse_vsync();
        drive_line(49, 2, 20);
        idle(10);
        compare(base);
        check(short_seen == exp_short, "R6", "no extra short pulses", short_seen, exp_short);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule